// File: doc/BRIEF.md
# Byte-Wide Host Bus Interface with Interrupt Control

This block connects a small microcontroller to a peripheral that exposes eight byte-wide registers. It works with either of the two common strobe conventions. One uses separate active-low read and write strobes. The other uses an active-low data strobe together with a direction line. It also works with either a separate address bus or a bus where the low data lines carry the register address during a latch phase. A static input picks the strobe convention. The addressing mode is read from the bit-0 address pin while reset is held.

The block decodes chip select and resolves the register address, latching it in multiplexed mode. It produces one write pulse per host write, drives the read data and its output enable, and keeps a register file with an interrupt status register and an interrupt mask. Status bits are set by internal event lines and cleared by the host writing ones. The active-low interrupt output is asserted whenever an unmasked status bit is set. The host signals are sampled on the block clock, so the host must hold each phase for at least one clock cycle.

Top module: `hostBusIf`

## Requirements
- R1: While `rstN` is low, all eight registers are cleared to zero and `irqN` is high. The addressing mode is sampled from `addrPins[0]` on every clock edge while `rstN` is low.
- R2: If `addrPins[0]` was high during reset, the interface uses separate-bus addressing. `addrPins[2:0]` selects the register, with bit 0 as the least significant bit.
- R3: If `addrPins[0]` was low during reset, the interface uses multiplexed addressing. `addrPins[2]` acts as the address latch enable, and the register address comes from `dataIn[2:0]`. The latch is transparent while the enable is high and holds its value once the enable falls. After that, `dataIn[2:0]` carries data only.
- R4: With `busStyle` = 0, a low `rdStrobeN` is a read and a low `wrStrobeN` is a write. A write stores `dataIn` into the selected register.
- R5: With `busStyle` = 1, `rdStrobeN` is an active-low data strobe and `wrStrobeN` is the direction line. While the strobe is low, direction 1 means a read and direction 0 means a write.
- R6: While `csN` is high, no register changes because of a strobe and `dataOe` stays low.
- R7: A write takes effect exactly once, using the `dataIn` value present in the first clock cycle of the selected write strobe. Later changes on `dataIn` during the same strobe are ignored.
- R8: Register 0 is interrupt status. An `eventIn` bit that is high at a clock edge sets the matching status bit. A host write to register 0 clears the bits written as 1 and leaves the bits written as 0. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R9: Register 1 is the interrupt mask. `irqN` is low exactly when some status bit and its mask bit are both 1. Registers 2 to 7 are plain storage.
- R10: `dataOe` is high only during a selected read, and then `dataOut` shows the selected register. At all other times `dataOut` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; host signals are sampled on its rising edge |
| rstN | input | 1 | Active-low reset |
| busStyle | input | 1 | Strobe convention: 0 uses read/write strobes, 1 uses data strobe with direction |
| addrPins | input | 3 | Register address pins; bit 0 is the mux strap during reset, bit 2 is the latch enable in multiplexed mode |
| dataIn | input | 8 | Host data bus, also the low address bits in multiplexed mode |
| dataOut | output | 8 | Read data toward the host bus |
| dataOe | output | 1 | Output enable for the host data bus |
| rdStrobeN | input | 1 | Read strobe, or data strobe when busStyle is 1 |
| wrStrobeN | input | 1 | Write strobe, or direction (1 means read) when busStyle is 1 |
| csN | input | 1 | Active-low chip select |
| eventIn | input | 8 | Interrupt event lines that set status bits |
| irqN | output | 1 | Active-low interrupt output |

## Verification
An internal event and a host write-one-to-clear can land on the same status bit in the same clock edge. The bench provokes this by raising `eventIn` in exactly the first cycle of a write strobe to register 0. It then judges the result by reading the status back through the bus: each bit the write cleared must read zero unless the event raised that bit again. The same scenario runs under all four combinations of strobe convention and addressing mode, mixed with seeded random traffic, so a write that lands in the wrong cycle is also caught.

// File: rtl/hostIfPkg.sv
package hostIfPkg;
  localparam int HOST_DATA_W = 8;
  localparam int HOST_ADDR_W = 3;

  typedef struct packed {
    logic                   wrPulse;
    logic                   rdEn;
    logic [HOST_ADDR_W-1:0] regAddr;
  } hostCtl_t;
endpackage

// File: rtl/hostCtrl.sv
module hostCtrl
  import hostIfPkg::*;
#(
  parameter int ADDR_W = HOST_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busStyle,
  input  logic [ADDR_W-1:0] addrPins,
  input  logic [ADDR_W-1:0] addrData,
  input  logic              rdStrobeN,
  input  logic              wrStrobeN,
  input  logic              csN,
  output hostCtl_t          ctl,
  output logic              dataOe
);
  localparam int ALE_BIT  = ADDR_W - 1;
  localparam int STRAP_BIT = 0;

  logic              muxMode;
  logic              ale;
  logic [ADDR_W-1:0] latchQ;
  logic [ADDR_W-1:0] regAddr;
  logic              rdReq;
  logic              wrReq;
  logic              wrActive;
  logic              wrPrevQ;

  // mode strap sampled while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) muxMode <= ~addrPins[STRAP_BIT];
  end

  assign ale = muxMode & addrPins[ALE_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    latchQ <= '0;
    else if (ale) latchQ <= addrData;
  end

  always_comb begin
    if (!muxMode)  regAddr = addrPins;
    else if (ale)  regAddr = addrData;
    else           regAddr = latchQ;
  end

  always_comb begin
    if (busStyle) begin
      rdReq = ~rdStrobeN & wrStrobeN;
      wrReq = ~rdStrobeN & ~wrStrobeN;
    end else begin
      rdReq = ~rdStrobeN;
      wrReq = ~wrStrobeN;
    end
  end

  assign wrActive = ~csN & wrReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPrevQ <= 1'b0;
    else       wrPrevQ <= wrActive;
  end

  assign dataOe      = rstN & ~csN & rdReq;
  assign ctl.wrPulse = wrActive & ~wrPrevQ;
  assign ctl.rdEn    = dataOe;
  assign ctl.regAddr = regAddr;
endmodule

// File: rtl/hostRegs.sv
module hostRegs
  import hostIfPkg::*;
#(
  parameter int DATA_W   = HOST_DATA_W,
  parameter int STAT_IDX = 0,
  parameter int MASK_IDX = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostCtl_t          ctl,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] eventIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] maskQ,
  output logic              irqN
);
  localparam int NUM_REGS = 1 << HOST_ADDR_W;

  logic [NUM_REGS-1:0][DATA_W-1:0] regQ;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit = ctl.wrPulse && (ctl.regAddr == HOST_ADDR_W'(i));
    if (i == STAT_IDX) begin : g_status
      // clear-by-one, with a new event taking precedence
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= (hit ? (q & ~dataIn) : q) | eventIn;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    q <= '0;
        else if (hit) q <= dataIn;
      end
    end
    assign regQ[i] = q;
  end

  assign statusQ = regQ[STAT_IDX];
  assign maskQ   = regQ[MASK_IDX];
  assign irqN    = ~|(statusQ & maskQ);
  assign dataOut = ctl.rdEn ? regQ[ctl.regAddr] : '0;
endmodule

// File: rtl/hostBusIf.sv
module hostBusIf
  import hostIfPkg::*;
#(
  parameter int DATA_W = HOST_DATA_W,
  parameter int ADDR_W = HOST_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busStyle,
  input  logic [ADDR_W-1:0] addrPins,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  input  logic              rdStrobeN,
  input  logic              wrStrobeN,
  input  logic              csN,
  input  logic [DATA_W-1:0] eventIn,
  output logic              irqN
);
  hostCtl_t          ctlBus;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] maskQ;

  hostCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busStyle(busStyle), .addrPins(addrPins),
    .addrData(dataIn[ADDR_W-1:0]), .rdStrobeN(rdStrobeN),
    .wrStrobeN(wrStrobeN), .csN(csN), .ctl(ctlBus), .dataOe(dataOe)
  );

  hostRegs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .dataIn(dataIn),
    .eventIn(eventIn), .dataOut(dataOut), .statusQ(statusQ),
    .maskQ(maskQ), .irqN(irqN)
  );
endmodule

// File: rtl/hostBusIfChk.sv
module hostBusIfChk
  import hostIfPkg::*;
#(
  parameter int DATA_W = HOST_DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              dataOe,
  input logic              irqN,
  input logic [DATA_W-1:0] eventIn,
  input hostCtl_t          ctl,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] maskQ
);
  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_state_chk: assert (irqN && statusQ == '0 && maskQ == '0);
    end
  end

  // R6
  deselect_no_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !dataOe);

  // R6
  deselect_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !ctl.wrPulse);

  // R7
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrPulse |=> !ctl.wrPulse);

  // R8
  event_sets_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventIn != '0) |=> ((statusQ & $past(eventIn)) == $past(eventIn)));

  // R9
  masked_event_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((eventIn & maskQ) != '0) && !ctl.wrPulse) |=> !irqN);
endmodule

bind hostBusIf hostBusIfChk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .dataOe(dataOe), .irqN(irqN),
  .eventIn(eventIn), .ctl(ctlBus), .statusQ(statusQ), .maskQ(maskQ)
);

// File: tb/hostBusIf_tb_top.sv
module hostBusIf_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busStyle = 1'b0;
  logic [2:0] addrPins = 3'b001;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       dataOe;
  logic       rdStrobeN = 1'b1;
  logic       wrStrobeN = 1'b1;
  logic       csN = 1'b1;
  logic [7:0] eventIn = '0;
  logic       irqN;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [8];
  bit   muxOn;
  string modeTag;

  always #2 clk = ~clk;

  hostBusIf dut_i (
    .clk(clk), .rstN(rstN), .busStyle(busStyle), .addrPins(addrPins),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN), .csN(csN),
    .eventIn(eventIn), .irqN(irqN)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic expIrqN();
    return ~|(mdl[0] & mdl[1]);
  endfunction

  task automatic idleBus();
    rdStrobeN = 1'b1;
    wrStrobeN = 1'b1;
    csN = 1'b1;
  endtask

  task automatic resetDut(input bit mux, input bit style);
    @(negedge clk);
    rstN = 1'b0;
    busStyle = style;
    addrPins = mux ? 3'b000 : 3'b001;
    idleBus();
    eventIn = '0;
    muxOn = mux;
    modeTag = {mux ? "R3" : "R2", "/", style ? "R5" : "R4"};
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // address phase, then strobe asserted at the following falling edge
  task automatic addrPhase(input logic [2:0] a);
    if (muxOn) begin
      @(negedge clk);
      addrPins = 3'b100;
      dataIn = {5'($urandom), a};
    end
    @(negedge clk);
    addrPins = muxOn ? 3'b000 : a;
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d, input logic [7:0] ev, input bit sel);
    addrPhase(a);
    dataIn = d;
    csN = ~sel;
    eventIn = ev;
    if (busStyle) begin rdStrobeN = 1'b0; wrStrobeN = 1'b0; end
    else          begin wrStrobeN = 1'b0; end
    @(negedge clk);
    eventIn = '0;
    dataIn = ~d;   // R7: late change during the same strobe
    @(negedge clk);
    idleBus();
    if (sel) begin
      if (a == 3'd0) mdl[0] = (mdl[0] & ~d) | ev;
      else begin mdl[a] = d; mdl[0] |= ev; end
    end else mdl[0] |= ev;
  endtask

  task automatic busRead(input logic [2:0] a, input bit sel, output logic [7:0] v, output logic oe);
    addrPhase(a);
    dataIn = 8'($urandom);   // bus released by host: low bits no longer address
    csN = ~sel;
    if (busStyle) begin rdStrobeN = 1'b0; wrStrobeN = 1'b1; end
    else          begin rdStrobeN = 1'b0; end
    #1;
    v = dataOut;
    oe = dataOe;
    @(negedge clk);
    idleBus();
  endtask

  task automatic checkReg(input logic [2:0] a);
    logic [7:0] v;
    logic oe;
    busRead(a, 1'b1, v, oe);
    chk(v == mdl[a], {modeTag, " read data"}, v, mdl[a]);
    chk(oe == 1'b1, "R10 oe during read", {7'd0, oe}, 8'd1);
  endtask

  task automatic pulseEvent(input logic [7:0] ev);
    @(negedge clk);
    eventIn = ev;
    @(negedge clk);
    eventIn = '0;
    mdl[0] |= ev;
  endtask

  task automatic checkIrq(input string what);
    #1;
    chk(irqN == expIrqN(), {"R9 irq ", what}, {7'd0, irqN}, {7'd0, expIrqN()});
  endtask

  task automatic runPhase(input bit mux, input bit style);
    logic [7:0] v;
    logic oe;
    resetDut(mux, style);
    #1;
    chk(irqN == 1'b1, "R1 irqN after reset", {7'd0, irqN}, 8'd1);
    chk(dataOe == 1'b0 && dataOut == 8'd0, "R10 idle bus", dataOut, 8'd0);
    for (int i = 0; i < 8; i++) checkReg(3'(i));   // R1 all zero
    // random traffic
    for (int n = 0; n < 24; n++) begin
      case ($urandom % 4)
        0: busWrite(3'(1 + $urandom % 7), 8'($urandom), 8'h00, 1'b1);
        1: checkReg(3'($urandom));
        2: pulseEvent(8'($urandom));
        default: busWrite(3'd0, 8'($urandom), 8'h00, 1'b1);
      endcase
      checkIrq("random");
    end
    for (int i = 0; i < 8; i++) checkReg(3'(i));
    // R8 same-cycle event and clear
    busWrite(3'd0, 8'hFF, 8'h00, 1'b1);
    busWrite(3'd1, 8'hFF, 8'h00, 1'b1);
    checkIrq("mask only");
    pulseEvent(8'h0F);
    checkIrq("event unmasked");
    busWrite(3'd0, 8'h05, 8'h01, 1'b1);
    busRead(3'd0, 1'b1, v, oe);
    chk(v == 8'h0B, "R8 event wins over clear", v, 8'h0B);
    // R6 deselected write and read
    busWrite(3'd3, 8'h5A, 8'h00, 1'b1);
    busWrite(3'd3, 8'hA5, 8'h00, 1'b0);
    busRead(3'd3, 1'b0, v, oe);
    chk(oe == 1'b0 && v == 8'h00, "R6 deselected read", v, 8'h00);
    checkReg(3'd3);
    // R9 mask gating then full clear
    busWrite(3'd1, 8'h00, 8'h00, 1'b1);
    checkIrq("masked off");
    busWrite(3'd1, 8'h08, 8'h00, 1'b1);
    checkIrq("single bit");
    busWrite(3'd0, 8'hFF, 8'h00, 1'b1);
    checkIrq("cleared");
    chk(irqN == 1'b1, "R9 irq released", {7'd0, irqN}, 8'd1);
  endtask

  initial begin
    void'($urandom(32'h5EED1));
    runPhase(1'b0, 1'b0);
    runPhase(1'b0, 1'b1);
    runPhase(1'b1, 1'b0);
    runPhase(1'b1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule